// File: doc/BRIEF.md
# B3ZS/HDB3 Selectable Line Encoder

This block sits on the transmit side of a coaxial line interface. It turns a binary NRZ stream into two logic rails, one for positive marks and one for negative marks, using alternate mark inversion (AMI). Long runs of zeros would starve the far-end clock recovery. To prevent this, the encoder replaces them with substitution codes that contain a deliberate bipolar violation (V). The substitution is B3ZS when the standard select is low (DS3/STS-1) and HDB3 when it is high (E3). A short delay line holds the last three or four bits, so that a substitution can reach back and place a balancing pulse (B) ahead of the violation.

When the active-low encoder enable is high, the encoder is bypassed. The two input rails then pass through a single register unchanged, for a framer that already produces dual-rail AMI. A polarity control picks which transmit clock edge samples the inputs. The mode and standard select are treated as static while a stream is running. The clock polarity is changed only while reset is held.

Top module: `line_code_encoder`

## Requirements
- R1: While rst_n is low, line_pos and line_neg are both 0.
- R2: With enc_en_n = 1 (bypass), after each active edge line_pos equals tx_data AND NOT tx_neg, and line_neg equals tx_neg AND NOT tx_data, both sampled at that edge (latency 1 cycle).
- R3: line_pos and line_neg are never 1 together. In bypass, both inputs high gives both outputs low.
- R4: With enc_en_n = 0 the data bit sampled at an edge appears on the rails after 3 active edges in B3ZS mode (e3_sel = 0) and after 4 in HDB3 mode (e3_sel = 1). The rails are 0 for those first edges after the encoder is enabled.
- R5: In encode mode every 1 bit gives one mark, and each mark has the opposite polarity to the previous pulse.
- R6: In B3ZS mode each run of three zeros becomes 00V if the number of pulses since the last substitution is odd, and B0V if it is even. The count starts even.
- R7: In HDB3 mode each run of four zeros becomes 000V if the count is odd, and B00V if it is even. The same count rule applies.
- R8: A V repeats the polarity of the pulse before it, and a B is an ordinary alternating pulse. Two successive pulses of the same polarity are therefore separated by exactly N-2 or N-1 zeros, where N is 3 (B3ZS) or 4 (HDB3).
- R9: In encode mode tx_neg has no effect on the rails.
- R10: With clk_inv = 1 the inputs are sampled and the rails updated on the falling edge of clk. With clk_inv = 0 this happens on the rising edge.
- R11: Bypass clears the encoder state. After enabling, the first mark is positive and the pulse count starts even.
- R12: After the pipeline has filled, the encoded rails never show N consecutive zero symbols.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_inv | input | 1 | 1 selects the falling edge of clk as the active edge |
| enc_en_n | input | 1 | 0 enables encoding, 1 selects dual-rail bypass |
| e3_sel | input | 1 | 0 selects B3ZS, 1 selects HDB3 |
| tx_data | input | 1 | NRZ data when encoding, positive rail in bypass |
| tx_neg | input | 1 | Negative rail in bypass, ignored when encoding |
| line_pos | output | 1 | Registered positive mark |
| line_neg | output | 1 | Registered negative mark |

## Verification
The in-RTL assertions watch every cycle for properties of the output stream alone. They check that the rails never fire together, that no zero run reaches the substitution length once the pipeline is full, that same-polarity pulse pairs sit exactly N-2 or N-1 zeros apart, and that the first encoded pulse is positive. They also check the bypass mapping of a lone negative input. Whether a substitution chose 00V or B0V correctly from the pulse parity, the exact latency, the ignored negative rail and the falling-edge sampling can only be seen by the bench. It compares every output against a symbol-level model driven with random and directed streams.

// File: rtl/line_code_encoder.sv
module line_code_encoder (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_inv,
  input  logic enc_en_n,
  input  logic e3_sel,
  input  logic tx_data,
  input  logic tx_neg,
  output logic line_pos,
  output logic line_neg
);
  logic       sclk;
  logic       enc_on;
  logic [2:0] run_len;
  logic [1:0] tap;
  logic [3:0] pul_q, vio_q, pul_d, vio_d;
  logic [2:0] zrun_q;
  logic       par_q, last_q;
  logic       subst, emit_p, emit_v, pol;

  assign sclk    = clk_inv ? ~clk : clk;
  assign enc_on  = !enc_en_n;
  assign run_len = e3_sel ? 3'd4 : 3'd3;
  assign tap     = e3_sel ? 2'd3 : 2'd2;
  assign subst   = !tx_data && (zrun_q == run_len - 3'd1);
  assign emit_p  = pul_q[tap];
  assign emit_v  = vio_q[tap];
  assign pol     = emit_v ? last_q : !last_q;

  always_comb begin
    pul_d = {pul_q[2:0], tx_data};
    vio_d = {vio_q[2:0], 1'b0};
    if (subst) begin
      pul_d[0] = 1'b1;
      vio_d[0] = 1'b1;
      if (!par_q) pul_d[tap] = 1'b1;
    end
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      pul_q <= '0; vio_q <= '0; zrun_q <= '0;
      par_q <= 1'b0; last_q <= 1'b0;
      line_pos <= 1'b0; line_neg <= 1'b0;
    end else if (!enc_on) begin
      pul_q <= '0; vio_q <= '0; zrun_q <= '0;
      par_q <= 1'b0; last_q <= 1'b0;
      line_pos <= tx_data & ~tx_neg;
      line_neg <= tx_neg & ~tx_data;
    end else begin
      pul_q  <= pul_d;
      vio_q  <= vio_d;
      zrun_q <= (tx_data || subst) ? 3'd0 : zrun_q + 3'd1;
      par_q  <= subst ? 1'b0 : (par_q ^ tx_data);
      if (emit_p) last_q <= pol;
      line_pos <= emit_p & pol;
      line_neg <= emit_p & ~pol;
    end
  end

  logic [2:0] warm_q, zc_q;
  logic       ppol_q, have_q, obs_valid, obs_pulse;
  assign obs_valid = warm_q > run_len;
  assign obs_pulse = line_pos | line_neg;

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      warm_q <= '0; zc_q <= '0; ppol_q <= 1'b0; have_q <= 1'b0;
    end else begin
      if (!enc_on) warm_q <= '0;
      else if (warm_q != 3'd7) warm_q <= warm_q + 3'd1;
      if (obs_valid) begin
        zc_q <= obs_pulse ? 3'd0 : zc_q + 3'd1;
        if (obs_pulse) begin
          ppol_q <= line_pos;
          have_q <= 1'b1;
        end
      end else begin
        zc_q   <= '0;
        have_q <= 1'b0;
      end
    end
  end

  assert_rails_exclusive_R3: assert property (@(posedge sclk) disable iff (!rst_n)
    !(line_pos && line_neg));

  assert_bypass_neg_R2: assert property (@(posedge sclk) disable iff (!rst_n)
    (enc_en_n && tx_neg && !tx_data) |=> (line_neg && !line_pos));

  assert_zero_run_R12: assert property (@(posedge sclk) disable iff (!rst_n)
    (obs_valid && !obs_pulse) |-> (zc_q < run_len - 3'd1));

  assert_same_pol_gap_R8: assert property (@(posedge sclk) disable iff (!rst_n)
    (obs_valid && have_q && obs_pulse && (line_pos == ppol_q)) |->
      (zc_q == run_len - 3'd2 || zc_q == run_len - 3'd1));

  assert_first_mark_pos_R11: assert property (@(posedge sclk) disable iff (!rst_n)
    (obs_valid && !have_q && obs_pulse) |-> line_pos);
endmodule

// File: tb/sim_line_code_encoder.sv
module sim_line_code_encoder;
  logic clk = 1'b0, rst_n = 1'b0, clk_inv = 1'b0, enc_en_n = 1'b1, e3_sel = 1'b0;
  logic tx_data = 1'b0, tx_neg = 1'b0;
  logic line_pos, line_neg;
  int vectors = 0, errors = 0;
  bit done = 1'b0;
  int sym [4096];
  int mi, mzc;
  bit mpar, mlast;

  line_code_encoder u0 (
    .clk(clk), .rst_n(rst_n), .clk_inv(clk_inv), .enc_en_n(enc_en_n),
    .e3_sel(e3_sel), .tx_data(tx_data), .tx_neg(tx_neg),
    .line_pos(line_pos), .line_neg(line_neg));

  always #10 clk = ~clk;

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  task automatic model_clear();
    mi = 0; mzc = 0; mpar = 1'b0; mlast = 1'b0;
  endtask

  task automatic check(string tag, bit ep, bit en);
    vectors++;
    if (line_pos !== ep || line_neg !== en) begin
      errors++;
      $display("FAIL %s: pos/neg=%b%b expected %b%b (vector %0d)",
               tag, line_pos, line_neg, ep, en, vectors);
    end
  endtask

  task automatic model_step(bit en_n, bit d, bit n, output bit ep, output bit eq);
    int nl;
    int s;
    bit p;
    ep = 1'b0; eq = 1'b0;
    if (en_n) begin
      ep = d & !n; eq = n & !d;
      model_clear();
      return;
    end
    nl = e3_sel ? 4 : 3;
    if (d) begin
      sym[mi] = 1; mzc = 0; mpar = !mpar;
    end else begin
      mzc++;
      if (mzc == nl) begin
        sym[mi] = 2;
        if (!mpar) sym[mi-nl+1] = 1;
        mpar = 1'b0; mzc = 0;
      end else sym[mi] = 0;
    end
    if (mi >= nl) begin
      s = sym[mi-nl];
      p = 1'b0;
      if (s == 1) begin p = !mlast; mlast = p; end
      else if (s == 2) p = mlast;
      ep = (s != 0) & p;
      eq = (s != 0) & !p;
    end
    mi++;
  endtask

  task automatic cycle(bit en_n, bit d, bit n, string tag);
    bit ep, eq;
    enc_en_n = en_n; tx_data = d; tx_neg = n;
    model_step(en_n, d, n, ep, eq);
    if (clk_inv) @(negedge clk); else @(posedge clk);
    #5;
    check(tag, ep, eq);
  endtask

  task automatic do_reset(bit inv, bit e3);
    rst_n = 1'b0;
    clk_inv = inv; e3_sel = e3; enc_en_n = 1'b1; tx_data = 1'b0; tx_neg = 1'b0;
    repeat (2) @(posedge clk);
    #5;
    check("R1", 1'b0, 1'b0);
    rst_n = 1'b1;
    model_clear();
  endtask

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    // B3ZS
    do_reset(1'b0, 1'b0);
    cycle(1'b0, 1'b1, 1'b0, "R4");
    for (int i = 0; i < 6; i++) cycle(1'b0, 1'b0, 1'b0, "R4");
    do_reset(1'b0, 1'b0);
    for (int i = 0; i < 30; i++) cycle(1'b0, 1'b0, 1'b0, "R6");
    for (int i = 0; i < 20; i++) cycle(1'b0, 1'b1, 1'b0, "R5");
    for (int i = 0; i < 40; i++) cycle(1'b0, (i % 5) == 0, 1'b0, "R6");
    for (int i = 0; i < 600; i++) cycle(1'b0, 1'($urandom % 2), 1'($urandom % 2), "R9");
    for (int i = 0; i < 600; i++) cycle(1'b0, ($urandom % 4) == 0, 1'b0, "R6");
    // HDB3
    do_reset(1'b0, 1'b1);
    cycle(1'b0, 1'b1, 1'b0, "R4");
    for (int i = 0; i < 7; i++) cycle(1'b0, 1'b0, 1'b0, "R4");
    do_reset(1'b0, 1'b1);
    for (int i = 0; i < 40; i++) cycle(1'b0, 1'b0, 1'b0, "R7");
    for (int i = 0; i < 60; i++) cycle(1'b0, (i % 6) == 0, 1'b0, "R7");
    for (int i = 0; i < 800; i++) cycle(1'b0, ($urandom % 3) == 0, 1'($urandom % 2), "R8");
    for (int i = 0; i < 600; i++) cycle(1'b0, 1'($urandom % 2), 1'b0, "R12");
    // bypass
    do_reset(1'b0, 1'b0);
    cycle(1'b1, 1'b1, 1'b1, "R3");
    for (int i = 0; i < 400; i++) begin
      bit d, n;
      d = 1'($urandom % 2); n = 1'($urandom % 2);
      cycle(1'b1, d, n, (d && n) ? "R3" : "R2");
    end
    // enable toggling without reset
    for (int seg = 0; seg < 30; seg++) begin
      bit en_n;
      int len;
      en_n = 1'(seg % 2);
      len = 2 + int'($urandom % 40);
      for (int i = 0; i < len; i++) cycle(en_n, ($urandom % 3) == 0, 1'($urandom % 2), "R11");
    end
    // falling-edge sampling
    do_reset(1'b1, 1'b0);
    for (int i = 0; i < 500; i++) cycle(1'b0, 1'($urandom % 2), 1'b0, "R10");
    for (int i = 0; i < 200; i++) cycle(1'b1, 1'($urandom % 2), 1'($urandom % 2), "R10");
    do_reset(1'b1, 1'b1);
    for (int i = 0; i < 500; i++) cycle(1'b0, ($urandom % 4) != 0, 1'b0, "R10");
    do_reset(1'b0, 1'b1);
    for (int i = 0; i < 300; i++) cycle(1'b0, ($urandom % 5) == 0, 1'b0, "R12");
    finish_run();
  end
endmodule